// File: doc/BRIEF.md
# Timer Channel with Event Flag

This block is a single channel of a 16-bit timer. A shared counter outside the block supplies the count value and its direction. Within the block, one channel value register serves four modes. In input capture it latches the counter on a chosen pin edge. In output compare it fires when the counter equals the stored value. In edge-aligned PWM and center-aligned PWM it derives an output level from the counter. All modes report events through one sticky flag, which can raise an interrupt request.

Software reaches the channel through a two-address register port with read and write strobes. A single write cannot clear the flag. Software must first read the status word while the flag is up, and then write a zero to the flag bit. Because of this, an event that occurs between those two accesses is not lost. When a new event arrives in the same cycle as the clear, the set takes priority.

Top module: `tmr_chan`

## Requirements
- R1: While reset is asserted and right after it, the flag, the interrupt request and the channel output are 0, and the channel value register reads 0.
- R2: The mode select is encoded 00 capture, 01 compare, 10 edge-aligned PWM, 11 center-aligned PWM. In compare mode, each cycle in which the counter equals the channel value sets the flag and toggles the channel output, both visible one cycle later.
- R3: In edge-aligned PWM mode the channel output is high one cycle after a cycle where the counter is below the channel value, and low otherwise. The flag is set one cycle after the counter equals the channel value, which is the end of the high phase.
- R4: In center-aligned PWM mode the output follows the same counter-below-value rule. The flag is set after a match while counting up (end of duty) and also after a match while counting down (start of duty).
- R5: In capture mode the pin edge is chosen by the edge select: 00 none, 01 rising, 10 falling, 11 both. The pin passes through a two-stage synchronizer. For a pin change presented before clock edge k, the flag rises at edge k+2. At that same edge the channel value register takes the counter value present in the cycle before it. An unselected edge leaves both the flag and the register unchanged.
- R6: The register port has two addresses. Address 0 is status: bit 0 is the flag and bit 1 is the channel output. Address 1 is the channel value. Reading address 0 while the flag is 1 arms a clear. A following write to address 0 with bit 0 equal to 0 then clears the flag. A write that no armed read preceded leaves the flag at 1.
- R7: If a flag-setting event occurs in the same cycle as an armed clearing write, the flag stays 1.
- R8: The interrupt request is 1 exactly when the flag is 1 and the interrupt enable input is 1.
- R9: A write to address 1 loads the channel value register, and reads of address 1 return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Shared timer counter value |
| cnt_dn | input | 1 | 1 while the shared counter counts down |
| mode | input | 2 | Channel mode select |
| edge_sel | input | 2 | Capture edge select |
| cap_pin | input | 1 | Asynchronous channel input pin |
| irq_en | input | 1 | Channel interrupt enable |
| bus_addr | input | 1 | Register address (0 status, 1 value) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| ch_out | output | 1 | Channel output pin |
| irq | output | 1 | Channel interrupt request |

## Verification
A stuck or wrongly armed clear state appears on `irq` in the cycle after the clearing write. The flag then either falls without a prior status read, or stays high after a proper read-then-write. A wrong edge decode or an off-by-one synchronizer shows up in the exact cycle `irq` rises after a pin change, and in the value then read from address 1. A PWM level error or a misplaced center-aligned match appears on `ch_out` or `irq` one cycle after the counter value that should cause it.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'b00,
    MODE_COMPARE = 2'b01,
    MODE_EPWM    = 2'b10,
    MODE_CPWM    = 2'b11
  } chan_mode_e;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_VALUE  = 1'b1;

  // Decide whether a transition between two sampled levels is one the
  // edge select asks for.
  function automatic logic edge_hit(input logic [1:0] sel,
                                    input logic now_lvl,
                                    input logic old_lvl);
    logic rise, fall;
    rise = now_lvl & ~old_lvl;
    fall = ~now_lvl & old_lvl;
    case (sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_async,
  input  logic [1:0] edge_sel,
  output logic       pin_sync,
  output logic       edge_pulse
);
  import tmr_chan_pkg::*;

  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin_async;
  end

  generate
    for (genvar i = 1; i < CHAIN; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign pin_sync   = chain_q[STAGES-1];
  assign edge_pulse = edge_hit(edge_sel, chain_q[STAGES-1], chain_q[STAGES]);

endmodule

// File: rtl/tmr_chan_evt.sv
module tmr_chan_evt #(
  parameter int W = 16
) (
  input  tmr_chan_pkg::chan_mode_e mode,
  input  logic [W-1:0]             cnt_val,
  input  logic                     cnt_dn,
  input  logic [W-1:0]             ch_val,
  input  logic                     cap_edge,
  input  logic                     out_q,
  output logic                     match,
  output logic                     cap_evt,
  output logic                     set_evt,
  output logic                     duty_start,
  output logic                     duty_end,
  output logic                     out_d
);
  import tmr_chan_pkg::*;

  function automatic logic below(input logic [W-1:0] c, input logic [W-1:0] v);
    below = (c < v);
  endfunction

  always_comb begin
    match      = (cnt_val == ch_val);
    cap_evt    = (mode == MODE_CAPTURE) && cap_edge;
    set_evt    = (mode == MODE_CAPTURE) ? cap_edge : match;
    duty_start = (mode == MODE_CPWM) && match && cnt_dn;
    duty_end   = (mode == MODE_CPWM) && match && !cnt_dn;
    case (mode)
      MODE_CAPTURE: out_d = out_q;
      MODE_COMPARE: out_d = match ? ~out_q : out_q;
      default:      out_d = below(cnt_val, ch_val);
    endcase
  end

endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_status,
  input  logic wr_status,
  input  logic wr_bit0,
  output logic flag,
  output logic armed,
  output logic clr_ok
);
  logic flag_d, armed_d;

  always_comb begin
    clr_ok = wr_status && !wr_bit0 && armed;
    if (set_evt)     flag_d = 1'b1;
    else if (clr_ok) flag_d = 1'b0;
    else             flag_d = flag;

    if (!flag_d)                armed_d = 1'b0;
    else if (rd_status && flag) armed_d = 1'b1;
    else if (wr_status)         armed_d = 1'b0;
    else                        armed_d = armed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_d;
      armed <= armed_d;
    end
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W         = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_dn,
  input  logic [1:0]   mode,
  input  logic [1:0]   edge_sel,
  input  logic         cap_pin,
  input  logic         irq_en,
  input  logic         bus_addr,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         ch_out,
  output logic         irq
);
  import tmr_chan_pkg::*;

  localparam int STAT_BITS = 2;

  chan_mode_e   mode_e;
  logic [W-1:0] ch_val;
  logic         pin_sync, cap_edge;
  logic         match, cap_evt, set_evt, duty_start, duty_end, out_d;
  logic         rd_status, wr_status, wr_value;
  logic         flag, armed, clr_ok;

  assign mode_e    = chan_mode_e'(mode);
  assign rd_status = bus_rd && (bus_addr == ADDR_STATUS);
  assign wr_status = bus_wr && (bus_addr == ADDR_STATUS);
  assign wr_value  = bus_wr && (bus_addr == ADDR_VALUE);

  tmr_chan_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_async  (cap_pin),
    .edge_sel   (edge_sel),
    .pin_sync   (pin_sync),
    .edge_pulse (cap_edge)
  );

  tmr_chan_evt #(.W(W)) u_evt (
    .mode       (mode_e),
    .cnt_val    (cnt_val),
    .cnt_dn     (cnt_dn),
    .ch_val     (ch_val),
    .cap_edge   (cap_edge),
    .out_q      (ch_out),
    .match      (match),
    .cap_evt    (cap_evt),
    .set_evt    (set_evt),
    .duty_start (duty_start),
    .duty_end   (duty_end),
    .out_d      (out_d)
  );

  tmr_chan_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_evt   (set_evt),
    .rd_status (rd_status),
    .wr_status (wr_status),
    .wr_bit0   (bus_wdata[0]),
    .flag      (flag),
    .armed     (armed),
    .clr_ok    (clr_ok)
  );

  // Capture has priority over a software write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)        ch_val <= '0;
    else if (cap_evt)  ch_val <= cnt_val;
    else if (wr_value) ch_val <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ch_out <= 1'b0;
    else        ch_out <= out_d;
  end

  always_comb begin
    if (bus_addr == ADDR_VALUE) bus_rdata = ch_val;
    else bus_rdata = {{(W-STAT_BITS){1'b0}}, ch_out, flag};
  end

  assign irq = flag && irq_en;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt_val,
  input logic [1:0]   mode,
  input logic [W-1:0] ch_val,
  input logic         set_evt,
  input logic         cap_evt,
  input logic         duty_end,
  input logic         wr_status,
  input logic         flag,
  input logic         armed,
  input logic         clr_ok,
  input logic         ch_out,
  input logic         irq
);

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  assert_pwm_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && (cnt_val < ch_val)) |=> ch_out);

  assert_cpwm_end_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    duty_end |=> (!ch_out && flag));

  assert_capture_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ch_val == $past(cnt_val)));

  assert_unarmed_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_status && !armed) |=> flag);

  assert_fall_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_ok));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_ok) |=> flag);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);

endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_val   (cnt_val),
  .mode      (mode),
  .ch_val    (ch_val),
  .set_evt   (set_evt),
  .cap_evt   (cap_evt),
  .duty_end  (duty_end),
  .wr_status (wr_status),
  .flag      (flag),
  .armed     (armed),
  .clr_ok    (clr_ok),
  .ch_out    (ch_out),
  .irq       (irq)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;

  localparam int W = 16;
  localparam int SIG_IRQ = 0;
  localparam int SIG_OUT = 1;

  typedef struct {
    int           cyc;
    int           sig;
    logic [W-1:0] exp;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_val = 16'd7;
  logic         cnt_dn = 1'b0;
  logic [1:0]   mode = 2'b01;
  logic [1:0]   edge_sel = 2'b00;
  logic         cap_pin = 1'b0;
  logic         irq_en = 1'b1;
  logic         bus_addr = 1'b0;
  logic         bus_rd = 1'b0;
  logic         bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         ch_out, irq;

  int   n_run = 0;
  int   n_fail = 0;
  int   cyc = 0;
  exp_t sb[$];

  tmr_chan #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_dn(cnt_dn),
    .mode(mode), .edge_sel(edge_sel), .cap_pin(cap_pin), .irq_en(irq_en),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_out(ch_out), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver side: queue an expectation d cycles after the current one.
  task automatic expect_at(int d, int sig, logic [W-1:0] e, string tag);
    exp_t it;
    it.cyc = cyc + d; it.sig = sig; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare queued items once their cycle is reached.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        exp_t it;
        it = sb.pop_front();
        if (it.sig == SIG_IRQ) check(it.tag, {{(W-1){1'b0}}, irq}, it.exp);
        else                   check(it.tag, {{(W-1){1'b0}}, ch_out}, it.exp);
      end
    end
  end

  task automatic tick(logic [W-1:0] v);
    @(negedge clk);
    cnt_val = v;
  endtask

  task automatic wr(logic a, logic [W-1:0] d, logic [W-1:0] cv_in, logic [W-1:0] cv_out);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cnt_val = cv_in;
    @(negedge clk);
    bus_wr = 1'b0; cnt_val = cv_out;
  endtask

  task automatic rd(logic a, logic [W-1:0] e, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(tag, bus_rdata, e);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic clear_flag(logic [W-1:0] stat, string tag);
    rd(1'b0, stat, tag);
    wr(1'b0, '0, cnt_val, cnt_val);
    expect_at(0, SIG_IRQ, 0, tag);
  endtask

  task automatic cap_run(logic lvl, logic [W-1:0] base, logic hit,
                         logic [W-1:0] val_exp, string tag);
    @(negedge clk);
    cap_pin = lvl; cnt_val = base;
    tick(base + 1);
    tick(base + 2);
    expect_at(0, SIG_IRQ, 0, tag);
    tick(base + 3);
    expect_at(0, SIG_IRQ, {{(W-1){1'b0}}, hit}, tag);
    tick(base + 4);
    rd(1'b1, val_exp, tag);
    if (hit) clear_flag(16'h0003, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    check("R1 irq in reset", {{(W-1){1'b0}}, irq}, 0);
    check("R1 out in reset", {{(W-1){1'b0}}, ch_out}, 0);
    bus_addr = 1'b1;
    #1;
    check("R1 value in reset", bus_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    expect_at(1, SIG_IRQ, 0, "R1 irq after reset");

    // Compare mode
    wr(1'b1, 16'd100, 7, 7);
    rd(1'b1, 16'd100, "R9 value readback");
    tick(50);  expect_at(1, SIG_IRQ, 0, "R2 no match");
    tick(100); expect_at(1, SIG_IRQ, 1, "R2 match flag");
               expect_at(1, SIG_OUT, 1, "R2 toggle high");
    tick(101); expect_at(1, SIG_IRQ, 1, "R2 flag sticky");
    wr(1'b0, '0, 101, 101);
    expect_at(0, SIG_IRQ, 1, "R6 unarmed write ignored");
    rd(1'b0, 16'h0003, "R6 status read");
    wr(1'b0, '0, 101, 101);
    expect_at(0, SIG_IRQ, 0, "R6 armed clear");

    tick(100); expect_at(1, SIG_IRQ, 1, "R2 second match");
               expect_at(1, SIG_OUT, 0, "R2 toggle low");
    tick(102);
    rd(1'b0, 16'h0001, "R7 arm");
    wr(1'b0, '0, 100, 103);
    expect_at(0, SIG_IRQ, 1, "R7 set wins");
    expect_at(0, SIG_OUT, 1, "R2 toggle in clear cycle");
    wr(1'b0, '0, 103, 103);
    expect_at(0, SIG_IRQ, 1, "R6 consumed arm");
    clear_flag(16'h0003, "R6 clear after set-wins");

    @(negedge clk); irq_en = 1'b0;
    tick(100); expect_at(1, SIG_IRQ, 0, "R8 masked");
    tick(104);
    @(negedge clk); irq_en = 1'b1;
    expect_at(0, SIG_IRQ, 1, "R8 unmasked");
    clear_flag(16'h0001, "R8 clear");

    // Edge-aligned PWM
    @(negedge clk); mode = 2'b10; cnt_val = 10;
    expect_at(1, SIG_OUT, 1, "R3 high below value");
    expect_at(1, SIG_IRQ, 0, "R3 no flag below");
    tick(100); expect_at(1, SIG_OUT, 0, "R3 low at match");
               expect_at(1, SIG_IRQ, 1, "R3 end-of-duty flag");
    tick(0);   expect_at(1, SIG_OUT, 1, "R3 high after rollover");
    clear_flag(16'h0003, "R3 clear");

    // Center-aligned PWM
    @(negedge clk); mode = 2'b11; cnt_dn = 1'b0; cnt_val = 99;
    expect_at(1, SIG_OUT, 1, "R4 high below value");
    tick(100); expect_at(1, SIG_IRQ, 1, "R4 up-count match flag");
               expect_at(1, SIG_OUT, 0, "R4 low at match");
    tick(101); expect_at(1, SIG_OUT, 0, "R4 low above value");
    clear_flag(16'h0001, "R4 clear end");
    @(negedge clk); cnt_dn = 1'b1; cnt_val = 100;
    expect_at(1, SIG_IRQ, 1, "R4 down-count match flag");
    tick(99);  expect_at(1, SIG_OUT, 1, "R4 high after start");
    clear_flag(16'h0003, "R4 clear start");

    // Capture
    @(negedge clk); mode = 2'b00; cnt_dn = 1'b0; edge_sel = 2'b01;
    cap_run(1'b1, 16'd2000, 1'b1, 16'd2002, "R5 rising selected");
    cap_run(1'b0, 16'd3000, 1'b0, 16'd2002, "R5 falling ignored");
    @(negedge clk); edge_sel = 2'b10;
    cap_run(1'b1, 16'd4000, 1'b0, 16'd2002, "R5 rising ignored");
    cap_run(1'b0, 16'd5000, 1'b1, 16'd5002, "R5 falling selected");
    @(negedge clk); edge_sel = 2'b11;
    cap_run(1'b1, 16'd6000, 1'b1, 16'd6002, "R5 both rising");
    cap_run(1'b0, 16'd7000, 1'b1, 16'd7002, "R5 both falling");
    @(negedge clk); edge_sel = 2'b00;
    cap_run(1'b1, 16'd8000, 1'b0, 16'd7002, "R5 capture off");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule